// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and a calendar as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A free-running 32.768 kHz enable is divided down inside the block to one tick per second. Each tick advances the seconds, and every rollover carries up the chain as far as the year. Month lengths and the February leap-year rule hold for the years 2000 through 2099.

Software sets any field through a single write port that picks the field with a select code. Counting carries on while writes happen. A write to seconds also restarts the sub-second divider, so the next tick comes one full second after that write. The hours byte holds its own 12/24-hour mode bit and an AM/PM bit. A halt input freezes the divider and so stops the time. A one-cycle update strobe goes out alongside each new time value, so that comparators downstream can sample on it.

Top module: `bcd_calendar`

## Requirements
- R1: Field select codes on wr_sel_i are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A write stores wr_data_i ANDed with a per-field mask: 0x7F for seconds, minutes and hours, 0x07 for day of week, 0x3F for date, 0x1F for month, 0xFF for year. The stored value is visible on the outputs in the cycle after the write edge.
- R2: Each tick increments the seconds in BCD. Seconds go from 0x59 to 0x00 and carry one into minutes. Minutes go from 0x59 to 0x00 and carry one into hours.
- R3: When hours bit 6 is 0 (24-hour mode), bits 5:4 hold the tens digit. Hours go from 0x23 to 0x00 and advance the calendar by one day.
- R4: When hours bit 6 is 1 (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 hold 1 to 12 in BCD. Hour 11 steps to 12 and toggles the PM bit. Hour 12 steps to 01. The calendar advances only on the step from 11 PM to 12 AM.
- R5: The date rolls from the last day of the month to 0x01 and advances the month. Months 04, 06, 09 and 11 end on day 30. Months 01, 03, 05, 07, 08, 10 and 12 end on day 31.
- R6: February ends on day 29 when the BCD year is divisible by 4 (00 counts as a leap year) and on day 28 otherwise.
- R7: Day of week counts from 1 to 7. It advances in the same cycle as the date and wraps from 7 to 1.
- R8: Month wraps from 0x12 to 0x01 and increments the year. Year wraps from 0x99 to 0x00.
- R9: A write to seconds clears the divider. The next tick comes after exactly PRESCALE more enabled cycles.
- R10: Writes to fields other than seconds leave the divider alone, and the tick stays on its schedule. When a write and a tick fall in the same cycle, the written field takes the written value and the other fields still advance.
- R11: While halt_i is 1, the divider holds its count and no field changes except through a write.
- R12: update_o is high for exactly one cycle, and it is the cycle in which the advanced time first appears on the outputs.
- R13: After reset the time is 00:00:00 in 24-hour mode, day of week is 1, the date is 01, the month is 01, the year is 00 and update_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | 32.768 kHz enable, one cycle wide per pulse |
| halt_i | input | 1 | 1 stops the divider and all counting |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select code |
| wr_data_i | input | 8 | BCD write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode and PM bits |
| wday_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| update_o | output | 1 | One-cycle strobe when a tick has advanced the time |

## Verification
The bench builds the block with PRESCALE set to 4, so each second takes four enabled cycles rather than 32768. With that setting, rollovers of the minute, hour, day, month and year take only a handful of cycles. Directed runs cover 23:59:59 on 31 December 99, the 11 PM to 12 AM step and the 12 to 01 step, and the end of February in leap years, in ordinary years and in year 00. Long random runs with sparse enables, halts and writes then check the divider restart and the same-cycle cases where a write and a tick coincide.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6
  } fld_e;

  localparam logic [7:0] MASK_SEC   = 8'h7F;
  localparam logic [7:0] MASK_HOUR  = 8'h7F;
  localparam logic [7:0] MASK_WDAY  = 8'h07;
  localparam logic [7:0] MASK_DATE  = 8'h3F;
  localparam logic [7:0] MASK_MONTH = 8'h1F;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // years 00..99 map to 2000..2099: every multiple of 4 is leap
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic halt_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && !halt_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i && !halt_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !clr_i) |=> $stable(cnt_q)); // R11

  generate
    if (DIV > 1) begin : g_clr_chk
      AST_CLR_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !tick_o); // R9
    end
  endgenerate

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] MAX_BCD = 8'h59,
  parameter logic [7:0] WR_MASK = 8'h7F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  logic [7:0] val_q;

  assign carry_o = inc_i && (val_q == MAX_BCD);
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (wr_i)   val_q <= wr_data_i & WR_MASK;
    else if (inc_i)  val_q <= (val_q == MAX_BCD) ? 8'h00 : bcd_inc(val_q);
  end

  AST_FIELD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && val_q == MAX_BCD) |=> (val_q == 8'h00)); // R2

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] hour_o,
  output logic       day_o
);
  logic [7:0] h_q;
  logic [7:0] h_nxt;
  logic       midnight;
  logic [7:0] lo12, lo24;

  assign lo12 = {3'b000, h_q[4:0]};
  assign lo24 = {2'b00, h_q[5:0]};

  always_comb begin
    h_nxt    = h_q;
    midnight = 1'b0;
    if (h_q[6]) begin
      if (lo12 == 8'h11) begin
        h_nxt    = {2'b01, ~h_q[5], 5'h12};
        midnight = h_q[5];
      end else if (lo12 == 8'h12) begin
        h_nxt = {2'b01, h_q[5], 5'h01};
      end else begin
        h_nxt = {2'b01, h_q[5], 5'(bcd_inc(lo12))};
      end
    end else begin
      if (lo24 == 8'h23) begin
        h_nxt    = 8'h00;
        midnight = 1'b1;
      end else begin
        h_nxt = {2'b00, 6'(bcd_inc(lo24))};
      end
    end
  end

  assign day_o  = inc_i && midnight;
  assign hour_o = h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     h_q <= 8'h00;
    else if (wr_i)   h_q <= wr_data_i & MASK_HOUR;
    else if (inc_i)  h_q <= h_nxt;
  end

  AST_PM_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && h_q[6] && h_q[4:0] == 5'h11) |=> (h_q[5] != $past(h_q[5]))); // R4
  AST_24H_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && h_q == 8'h23) |=> (h_q == 8'h00)); // R3

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       day_inc_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic [7:0] wday_q, date_q, month_q, year_q;
  logic       date_carry, month_carry;
  logic       wr_wday, wr_date, wr_month, wr_year;

  assign date_carry  = day_inc_i && (date_q == last_date(month_q, year_q));
  assign month_carry = date_carry && (month_q == 8'h12);

  assign wr_wday  = wr_en_i && (wr_sel_i == FLD_WDAY);
  assign wr_date  = wr_en_i && (wr_sel_i == FLD_DATE);
  assign wr_month = wr_en_i && (wr_sel_i == FLD_MONTH);
  assign wr_year  = wr_en_i && (wr_sel_i == FLD_YEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wday_q  <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (wr_wday)         wday_q <= wr_data_i & MASK_WDAY;
      else if (day_inc_i)  wday_q <= (wday_q == 8'h07) ? 8'h01 : wday_q + 8'd1;

      if (wr_date)         date_q <= wr_data_i & MASK_DATE;
      else if (day_inc_i)  date_q <= date_carry ? 8'h01 : bcd_inc(date_q);

      if (wr_month)        month_q <= wr_data_i & MASK_MONTH;
      else if (date_carry) month_q <= (month_q == 8'h12) ? 8'h01 : bcd_inc(month_q);

      if (wr_year)          year_q <= wr_data_i;
      else if (month_carry) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign wday_o  = wday_q;
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;

  AST_WDAY_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_inc_i && !wr_en_i) |=> (wday_q != $past(wday_q))); // R7
  AST_DATE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (date_carry && !wr_en_i) |=> (date_q == 8'h01)); // R5
  AST_MONTH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (month_carry && !wr_en_i) |=> (month_q == 8'h01 && year_q != $past(year_q))); // R8

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_en_i,
  input  logic       halt_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       update_o
);
  localparam int unsigned NUM_LOW = 2;  // seconds, minutes

  logic       tick;
  logic       sec_wr;
  logic       day_inc;
  logic       update_q;
  logic       inc_chain [NUM_LOW+1];
  logic [7:0] low_val   [NUM_LOW];

  assign sec_wr = wr_en_i && (wr_sel_i == FLD_SEC);

  rtc_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en_i),
    .halt_i (halt_i),
    .clr_i  (sec_wr),
    .tick_o (tick)
  );

  assign inc_chain[0] = tick;

  generate
    for (genvar g = 0; g < NUM_LOW; g++) begin : g_low
      rtc_bcd_field #(.MAX_BCD(8'h59), .WR_MASK(MASK_SEC)) u_fld (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (inc_chain[g]),
        .wr_i      (wr_en_i && (wr_sel_i == 3'(g))),
        .wr_data_i (wr_data_i),
        .val_o     (low_val[g]),
        .carry_o   (inc_chain[g+1])
      );
    end
  endgenerate

  rtc_hour_field u_hour (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc_chain[NUM_LOW]),
    .wr_i      (wr_en_i && (wr_sel_i == FLD_HOUR)),
    .wr_data_i (wr_data_i),
    .hour_o    (hour_o),
    .day_o     (day_inc)
  );

  rtc_date_chain u_date (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .day_inc_i (day_inc),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .wday_o    (wday_o),
    .date_o    (date_o),
    .month_o   (month_o),
    .year_o    (year_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) update_q <= 1'b0;
    else         update_q <= tick;
  end

  assign sec_o    = low_val[0];
  assign min_o    = low_val[1];
  assign update_o = update_q;

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !wr_en_i) |=> $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o})); // R11
  AST_UPD_SEC_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (sec_o != $past(sec_o))); // R12
  AST_UPD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o && PRESCALE > 1) |=> !update_o); // R12

endmodule

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, hl = 1'b0, we = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] wd = '0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
  logic       update_o;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_sec, m_min, m_hr, m_wd, m_dt, m_mo, m_yr, pc;
  bit m_12, m_pm, m_upd;

  always #5 clk = ~clk;

  bcd_calendar #(.PRESCALE(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(en), .halt_i(hl),
    .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(wd),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .update_o(update_o)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int unbcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_byte();
    if (m_12) return 8'h40 | (m_pm ? 8'h20 : 8'h00) | bcd(m_hr);
    return bcd(m_hr);
  endfunction

  function automatic logic [63:0] exp_vec();
    return {bcd(m_sec), bcd(m_min), hour_byte(), bcd(m_wd), bcd(m_dt),
            bcd(m_mo), bcd(m_yr), 7'd0, m_upd};
  endfunction

  function automatic logic [63:0] act_vec();
    return {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o, 7'd0, update_o};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic adv_day();
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_dt++;
    if (m_dt > dim(m_mo, m_yr)) begin
      m_dt = 1;
      m_mo++;
      if (m_mo > 12) begin
        m_mo = 1;
        m_yr = (m_yr + 1) % 100;
      end
    end
  endtask

  task automatic model_tick();
    bit day = 0;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0;
      m_min++;
      if (m_min == 60) begin
        m_min = 0;
        if (m_12) begin
          if (m_hr == 11) begin m_hr = 12; m_pm = !m_pm; day = !m_pm; end
          else if (m_hr == 12) m_hr = 1;
          else m_hr++;
        end else begin
          m_hr++;
          if (m_hr == 24) begin m_hr = 0; day = 1; end
        end
        if (day) adv_day();
      end
    end
  endtask

  task automatic model_write(input logic [2:0] s, input logic [7:0] d);
    case (s)
      3'd0: m_sec = unbcd(d & 8'h7F);
      3'd1: m_min = unbcd(d & 8'h7F);
      3'd2: begin
        m_12 = d[6];
        m_pm = d[6] & d[5];
        m_hr = d[6] ? unbcd({3'b0, d[4:0]}) : unbcd({2'b0, d[5:0]});
      end
      3'd3: m_wd = int'(d & 8'h07);
      3'd4: m_dt = unbcd(d & 8'h3F);
      3'd5: m_mo = unbcd(d & 8'h1F);
      3'd6: m_yr = unbcd(d);
      default: ;
    endcase
  endtask

  // one clock: drive at negedge, model the edge, compare 2 ns after it
  task automatic cyc(input bit e, input bit h, input bit w, input logic [2:0] s,
                     input logic [7:0] d, input string tag);
    bit tk;
    bit sw;
    @(negedge clk);
    en = e; hl = h; we = w; sel = s; wd = d;
    sw = w && (s == 3'd0);
    tk = !sw && e && !h && (pc == P - 1);
    if (sw) pc = 0;
    else if (e && !h) pc = (pc == P - 1) ? 0 : pc + 1;
    if (tk) model_tick();
    if (w) model_write(s, d);
    m_upd = tk;
    @(posedge clk);
    #2;
    chk(tag, act_vec(), exp_vec());
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    cyc(1'b0, 1'b0, 1'b1, s, d, "R1 write");
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, tag);
  endtask

  task automatic set_all(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] dt,
                         input logic [7:0] w, input logic [7:0] h, input logic [7:0] mi,
                         input logic [7:0] s);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, w);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int first;
    void'($urandom(32'hC0FFEE));
    m_sec = 0; m_min = 0; m_hr = 0; m_12 = 0; m_pm = 0;
    m_wd = 1; m_dt = 1; m_mo = 1; m_yr = 0; pc = 0; m_upd = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R13 reset state", act_vec(), exp_vec());
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R13 after release", act_vec(), exp_vec());

    // field masks
    wr(3'd0, 8'hC5);
    chk("R1 seconds mask", {56'd0, sec_o}, 64'h45);
    wr(3'd3, 8'h0F);
    chk("R1 day-of-week mask", {56'd0, wday_o}, 64'h07);

    // end of century rollover, 24-hour mode
    set_all(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
    run(2 * P, "R2 R12 rollover chain");
    chk("R3 hour wrap 23->00", {56'd0, hour_o}, 64'h00);
    chk("R7 day-of-week 7->1", {56'd0, wday_o}, 64'h01);
    chk("R8 month and year wrap", {48'd0, month_o, year_o}, {48'd0, 16'h0100});

    // 11 PM -> 12 AM into leap day
    set_all(8'h24, 8'h02, 8'h28, 8'h03, 8'h71, 8'h59, 8'h59);
    run(P, "R4 R6 11PM step");
    chk("R4 12 AM after 11 PM", {56'd0, hour_o}, 64'h52);
    chk("R6 leap Feb 29", {56'd0, date_o}, 64'h29);
    wr(3'd2, 8'h51); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    run(P, "R4 11AM step");
    chk("R4 12 PM after 11 AM, no day", {48'd0, hour_o, date_o}, {48'd0, 16'h7229});
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    run(P, "R4 12 to 01");
    chk("R4 12 PM -> 01 PM", {56'd0, hour_o}, 64'h61);

    // February in an ordinary year and in year 00
    set_all(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    run(P, "R6 ordinary Feb");
    chk("R6 Feb 28 -> Mar 01", {48'd0, month_o, date_o}, {48'd0, 16'h0301});
    set_all(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    run(P, "R6 year 00");
    chk("R6 year 00 leap", {56'd0, date_o}, 64'h29);

    // 30- and 31-day months
    set_all(8'h10, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    run(P, "R5 April");
    chk("R5 Apr 30 -> May 01", {48'd0, month_o, date_o}, {48'd0, 16'h0501});
    set_all(8'h10, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    run(P, "R5 January");
    chk("R5 Jan 31 -> Feb 01", {48'd0, month_o, date_o}, {48'd0, 16'h0201});
    set_all(8'h10, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    run(P, "R5 November");
    chk("R5 Nov 30 -> Dec 01", {48'd0, month_o, date_o}, {48'd0, 16'h1201});

    // halt
    run(2, "R11 pre-halt");
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, 8'h00, "R11 halted");
    first = 0;
    for (int i = 1; i <= P && first == 0; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R11 resume");
      if (update_o) first = i;
    end
    chk("R11 divider held during halt", 64'(first), 64'(P - 2));

    // seconds write restarts the divider
    run(2, "R9 partial");
    wr(3'd0, 8'h10);
    first = 0;
    for (int i = 1; i <= P + 2 && first == 0; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R9 count");
      if (update_o) first = i;
    end
    chk("R9 tick after seconds write", 64'(first), 64'(P));

    // other writes keep the schedule
    run(2, "R10 partial");
    wr(3'd1, 8'h33);
    first = 0;
    for (int i = 1; i <= P + 2 && first == 0; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R10 count");
      if (update_o) first = i;
    end
    chk("R10 tick unaffected by minute write", 64'(first), 64'(P - 2));

    // write in the same cycle as a rolling tick
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    run(P - 1, "R10 approach");
    cyc(1'b1, 1'b0, 1'b1, 3'd4, 8'h15, "R10 write with tick");
    chk("R10 minute advanced with date write", {48'd0, min_o, date_o}, {48'd0, 16'h0015});

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit e, h, w;
      logic [2:0] s;
      logic [7:0] d;
      e = ($urandom % 3) != 0;
      h = ($urandom % 40) == 0;
      w = ($urandom % 25) == 0;
      s = 3'($urandom % 7);
      d = 8'h00;
      case (s)
        3'd0, 3'd1: d = bcd($urandom % 60);
        3'd2: d = ($urandom % 2) ? (8'h40 | (($urandom % 2) ? 8'h20 : 8'h00) | bcd(1 + $urandom % 12))
                                 : bcd($urandom % 24);
        3'd3: d = bcd(1 + $urandom % 7);
        3'd4: d = bcd(1 + $urandom % 28);
        3'd5: begin s = 3'd6; d = bcd(4 * ($urandom % 25)); end
        default: d = (m_mo == 2) ? bcd(4 * ($urandom % 25)) : bcd($urandom % 100);
      endcase
      cyc(e, h, w, s, d, "R2 R10 R12 random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule